// File: doc/BRIEF.md
# Packet Receiver with Acknowledgment Return

This block is the receive end of a point-to-point packet link. Each cycle it may take one 32-bit packet, made of an 8-bit header on top and a 24-bit body below it. The top two header bits give the packet's kind and the six bits under them carry a tag. Data and control packets go to a downstream consumer with a one-bit kind flag, the tag and the body. Void packets are dropped and get no response.

For every data or control packet, the block sends a 7-bit acknowledgment code back toward the transmitter in the same cycle as the delivery. The code has its top bit set and the packet's tag in its low six bits. When a header has a malformed encoding, the block raises a one-cycle protocol error flag.

Every output is registered, so all results appear exactly one clock after the packet is presented. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block starts accepting packets two clock edges after the reset input goes high.

Top module: `pkt_ack_rx`

## Requirements
- R1: A packet with header kind bits [31:30] = 2'b10 (data) is delivered on the next cycle with `out_valid` = 1, `out_is_data` = 1, `out_tag` = header bits [29:24] and `out_body` = packet bits [23:0].
- R2: A packet with header kind bits 2'b01 (control) is delivered on the next cycle with `out_is_data` = 0, `out_tag` = 0 and `out_body` = packet bits [23:0], and its acknowledgment code is 7'b1000000.
- R3: Every data or control packet produces, on the next cycle, `ack_valid` high for exactly that one cycle, with `ack_code` = {1'b1, delivered tag}.
- R4: A packet with kind bits 2'b00 (void) produces no delivery, no acknowledgment and no protocol error on the next cycle, whatever its tag and body hold.
- R5: A packet with kind bits 2'b11 (reserved) produces no delivery and no acknowledgment, and raises `proto_err` for the next cycle only.
- R6: A control packet whose header bits [29:24] are non-zero is still delivered and acknowledged with tag 0, and it raises `proto_err` on the next cycle.
- R7: While reset is held, and until the first packet has been taken after reset, `out_valid`, `ack_valid` and `proto_err` are low.
- R8: A cycle with `in_valid` low produces no delivery, no acknowledgment and no protocol error on the next cycle.
- R9: Packets presented on consecutive cycles each get their own delivery and acknowledgment, on consecutive cycles and in arrival order.
- R10: `ack_valid` is high in exactly the cycles in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Packet on `in_pkt` is present this cycle |
| in_pkt | input | 32 | Header in [31:24], body in [23:0] |
| out_valid | output | 1 | Delivery to the consumer this cycle |
| out_is_data | output | 1 | 1 = data packet, 0 = control packet |
| out_tag | output | 6 | Delivered tag (zero for control) |
| out_body | output | 24 | Delivered three-byte body |
| ack_valid | output | 1 | Acknowledgment pulse toward the transmitter |
| ack_code | output | 7 | {1'b1, tag} of the acknowledged packet |
| proto_err | output | 1 | One-cycle pulse for a malformed header |

## Verification
The assertions assume that `in_valid` and `in_pkt` carry known values in every cycle after the internal reset release. They also assume that a packet's header is fully defined whenever `in_valid` is high, because each check looks only at the header presented one cycle earlier. The stimulus holds `in_valid` low with a zeroed packet through reset and for several cycles after it. After that it changes inputs only on falling clock edges and always drives defined headers, including every kind encoding and both clean and dirty control tags. Directed runs of back-to-back packets and random runs with idle gaps keep the one-cycle input-to-output relation under test.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  // Header kind field, taken from the two top header bits.
  typedef enum logic [1:0] {
    PK_VOID = 2'b00,
    PK_CTRL = 2'b01,
    PK_DATA = 2'b10,
    PK_RSVD = 2'b11
  } pk_kind_e;

  // Width of the kind field, which sits above the tag.
  localparam int unsigned KIND_W = 2;

endpackage

// File: rtl/pkt_rx_rst_sync.sv
module pkt_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign run_n = chain_q[STAGES-1];

endmodule

// File: rtl/pkt_rx_decode.sv
module pkt_rx_decode
  import pkt_rx_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned BODY_W = 24
) (
  input  logic                           in_valid,
  input  logic [KIND_W+TAG_W+BODY_W-1:0] in_pkt,
  output logic                           take,
  output logic                           is_data,
  output logic [TAG_W-1:0]               tag_eff,
  output logic [BODY_W-1:0]              body,
  output logic                           bad_hdr
);

  localparam int unsigned HDR_W = KIND_W + TAG_W;
  localparam int unsigned PKT_W = HDR_W + BODY_W;

  pk_kind_e           kind;
  logic [TAG_W-1:0]   low_bits;

  assign kind     = pk_kind_e'(in_pkt[PKT_W-1 -: KIND_W]);
  assign low_bits = in_pkt[PKT_W-KIND_W-1 -: TAG_W];
  assign body     = in_pkt[BODY_W-1:0];

  always_comb begin
    take    = 1'b0;
    is_data = 1'b0;
    tag_eff = '0;
    bad_hdr = 1'b0;
    if (in_valid) begin
      unique case (kind)
        PK_DATA: begin
          take    = 1'b1;
          is_data = 1'b1;
          tag_eff = low_bits;
        end
        PK_CTRL: begin
          take    = 1'b1;
          bad_hdr = (low_bits != '0);
        end
        PK_RSVD: begin
          bad_hdr = 1'b1;
        end
        default: begin
          // void: contents ignored
        end
      endcase
    end
  end

endmodule

// File: rtl/pkt_rx_deliver.sv
module pkt_rx_deliver #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned BODY_W = 24
) (
  input  logic              clk,
  input  logic              run_n,
  input  logic              take,
  input  logic              is_data,
  input  logic [TAG_W-1:0]  tag_eff,
  input  logic [BODY_W-1:0] body,
  output logic              out_valid,
  output logic              out_is_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic [BODY_W-1:0] out_body
);

  logic              vld_d;
  logic              kind_d;
  logic [TAG_W-1:0]  tag_d;
  logic [BODY_W-1:0] body_d;

  // Payload registers load only when a packet is taken.
  always_comb begin
    vld_d  = take;
    kind_d = out_is_data;
    tag_d  = out_tag;
    body_d = out_body;
    if (take) begin
      kind_d = is_data;
      tag_d  = tag_eff;
      body_d = body;
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      out_valid   <= 1'b0;
      out_is_data <= 1'b0;
      out_tag     <= '0;
      out_body    <= '0;
    end else begin
      out_valid   <= vld_d;
      out_is_data <= kind_d;
      out_tag     <= tag_d;
      out_body    <= body_d;
    end
  end

endmodule

// File: rtl/pkt_rx_ack.sv
module pkt_rx_ack #(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             run_n,
  input  logic             take,
  input  logic [TAG_W-1:0] tag_eff,
  input  logic             bad_hdr,
  output logic             ack_valid,
  output logic [TAG_W:0]   ack_code,
  output logic             proto_err
);

  logic           ack_vld_d;
  logic [TAG_W:0] code_d;
  logic           err_d;

  always_comb begin
    ack_vld_d = take;
    err_d     = bad_hdr;
    code_d    = ack_code;
    if (take) begin
      code_d = {1'b1, tag_eff};
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      ack_valid <= 1'b0;
      ack_code  <= '0;
      proto_err <= 1'b0;
    end else begin
      ack_valid <= ack_vld_d;
      ack_code  <= code_d;
      proto_err <= err_d;
    end
  end

endmodule

// File: rtl/pkt_ack_rx.sv
module pkt_ack_rx
  import pkt_rx_pkg::*;
#(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned BODY_W = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [KIND_W+TAG_W+BODY_W-1:0] in_pkt,
  output logic                           out_valid,
  output logic                           out_is_data,
  output logic [TAG_W-1:0]               out_tag,
  output logic [BODY_W-1:0]              out_body,
  output logic                           ack_valid,
  output logic [TAG_W:0]                 ack_code,
  output logic                           proto_err
);

  logic              run_n;
  logic              take;
  logic              is_data;
  logic [TAG_W-1:0]  tag_eff;
  logic [BODY_W-1:0] body;
  logic              bad_hdr;

  pkt_rx_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  pkt_rx_decode #(.TAG_W(TAG_W), .BODY_W(BODY_W)) u_dec (
    .in_valid (in_valid),
    .in_pkt   (in_pkt),
    .take     (take),
    .is_data  (is_data),
    .tag_eff  (tag_eff),
    .body     (body),
    .bad_hdr  (bad_hdr)
  );

  pkt_rx_deliver #(.TAG_W(TAG_W), .BODY_W(BODY_W)) u_dlv (
    .clk         (clk),
    .run_n       (run_n),
    .take        (take),
    .is_data     (is_data),
    .tag_eff     (tag_eff),
    .body        (body),
    .out_valid   (out_valid),
    .out_is_data (out_is_data),
    .out_tag     (out_tag),
    .out_body    (out_body)
  );

  pkt_rx_ack #(.TAG_W(TAG_W)) u_ack (
    .clk       (clk),
    .run_n     (run_n),
    .take      (take),
    .tag_eff   (tag_eff),
    .bad_hdr   (bad_hdr),
    .ack_valid (ack_valid),
    .ack_code  (ack_code),
    .proto_err (proto_err)
  );

endmodule

// File: rtl/pkt_ack_rx_chk.sv
module pkt_ack_rx_chk #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned BODY_W = 24
) (
  input logic                    clk,
  input logic                    run_n,
  input logic                    in_valid,
  input logic [2+TAG_W+BODY_W-1:0] in_pkt,
  input logic                    out_valid,
  input logic                    out_is_data,
  input logic [TAG_W-1:0]        out_tag,
  input logic [BODY_W-1:0]       out_body,
  input logic                    ack_valid,
  input logic [TAG_W:0]          ack_code,
  input logic                    proto_err
);

  localparam int unsigned PKT_W = 2 + TAG_W + BODY_W;

  logic [1:0]       hk;
  logic [TAG_W-1:0] hlow;
  logic             p_data;
  logic             p_ctrl;
  logic             p_void;
  logic             p_rsvd;

  assign hk     = in_pkt[PKT_W-1 -: 2];
  assign hlow   = in_pkt[PKT_W-3 -: TAG_W];
  assign p_data = in_valid && (hk == 2'b10);
  assign p_ctrl = in_valid && (hk == 2'b01);
  assign p_void = in_valid && (hk == 2'b00);
  assign p_rsvd = in_valid && (hk == 2'b11);

  AST_DATA_DELIVERED: assert property (@(posedge clk) disable iff (!run_n)
    p_data |=> out_valid && out_is_data && (out_tag == $past(hlow)) && (out_body == $past(in_pkt[BODY_W-1:0]))); // R1

  AST_CTRL_TAG_ZERO: assert property (@(posedge clk) disable iff (!run_n)
    p_ctrl |=> out_valid && !out_is_data && (out_tag == '0) && (ack_code == {1'b1, {TAG_W{1'b0}}})); // R2

  AST_ACK_ECHOES_TAG: assert property (@(posedge clk) disable iff (!run_n)
    (p_data || p_ctrl) |=> ack_valid && (ack_code == {1'b1, out_tag})); // R3

  AST_VOID_SILENT: assert property (@(posedge clk) disable iff (!run_n)
    p_void |=> !ack_valid && !out_valid && !proto_err); // R4

  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!run_n)
    p_rsvd |=> proto_err && !ack_valid && !out_valid); // R5

  AST_CTRL_DIRTY_FLAGGED: assert property (@(posedge clk) disable iff (!run_n)
    (p_ctrl && (hlow != '0)) |=> proto_err && ack_valid); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!run_n)
    !in_valid |=> !ack_valid && !out_valid && !proto_err); // R8

  AST_ACK_PAIRED: assert property (@(posedge clk) disable iff (!run_n)
    ack_valid == out_valid); // R10

endmodule

bind pkt_ack_rx pkt_ack_rx_chk #(.TAG_W(TAG_W), .BODY_W(BODY_W)) u_chk (
  .clk         (clk),
  .run_n       (run_n),
  .in_valid    (in_valid),
  .in_pkt      (in_pkt),
  .out_valid   (out_valid),
  .out_is_data (out_is_data),
  .out_tag     (out_tag),
  .out_body    (out_body),
  .ack_valid   (ack_valid),
  .ack_code    (ack_code),
  .proto_err   (proto_err)
);

// File: tb/pkt_ack_rx_bench.sv
module pkt_ack_rx_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        dlv;
    logic        is_data;
    logic [5:0]  tag;
    logic [23:0] body;
    logic        ack;
    logic [6:0]  code;
    logic        err;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_pkt;
  logic        out_valid;
  logic        out_is_data;
  logic [5:0]  out_tag;
  logic [23:0] out_body;
  logic        ack_valid;
  logic [6:0]  ack_code;
  logic        proto_err;

  int checks;
  int errors;
  bit done;

  exp_t  exp_q[$];
  string req_q[$];

  pkt_ack_rx u_pkt_ack_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_pkt      (in_pkt),
    .out_valid   (out_valid),
    .out_is_data (out_is_data),
    .out_tag     (out_tag),
    .out_body    (out_body),
    .ack_valid   (ack_valid),
    .ack_code    (ack_code),
    .proto_err   (proto_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle (packet or idle) and push the expected result.
  task automatic drive(input logic v, input logic [31:0] pkt, input string req);
    exp_t e;
    logic [1:0] k;
    @(negedge clk);
    in_valid = v;
    in_pkt   = pkt;
    k = pkt[31:30];
    e = '0;
    if (v) begin
      e.body = pkt[23:0];
      if (k == 2'b10) begin
        e.dlv = 1'b1; e.is_data = 1'b1; e.tag = pkt[29:24];
        e.ack = 1'b1; e.code = {1'b1, pkt[29:24]};
      end else if (k == 2'b01) begin
        e.dlv = 1'b1; e.is_data = 1'b0; e.tag = 6'd0;
        e.ack = 1'b1; e.code = 7'h40;
        e.err = (pkt[29:24] != 6'd0);
      end else if (k == 2'b11) begin
        e.err = 1'b1;
      end
    end
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1'b0, 32'h0, req);
  endtask

  // Monitor: compare each cycle's outputs just after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({r, "/R10"}, "out_valid", {31'd0, out_valid}, {31'd0, e.dlv});
        check({r, "/R3"}, "ack_valid", {31'd0, ack_valid}, {31'd0, e.ack});
        check(r, "proto_err", {31'd0, proto_err}, {31'd0, e.err});
        if (e.dlv) begin
          check(r, "out_is_data", {31'd0, out_is_data}, {31'd0, e.is_data});
          check(r, "out_tag", {26'd0, out_tag}, {26'd0, e.tag});
          check(r, "out_body", {8'd0, out_body}, {8'd0, e.body});
        end
        if (e.ack) check({r, "/R3"}, "ack_code", {25'd0, ack_code}, {25'd0, e.code});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_pkt   = 32'h0;
    repeat (3) @(negedge clk);
    // R7: outputs quiet while reset is held
    check("R7", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R7", "ack_valid", {31'd0, ack_valid}, 32'd0);
    check("R7", "proto_err", {31'd0, proto_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7", "ack_valid after release", {31'd0, ack_valid}, 32'd0);

    // R1 data packets with edge tags
    drive(1'b1, {2'b10, 6'd0,  24'hA1B2C3}, "R1");
    idle(1, "R8");
    drive(1'b1, {2'b10, 6'd63, 24'hFFFFFF}, "R1");
    drive(1'b1, {2'b10, 6'd21, 24'h000001}, "R1");
    idle(2, "R8");
    // R2 clean control
    drive(1'b1, {2'b01, 6'd0, 24'h5A5A5A}, "R2");
    idle(1, "R8");
    // R6 dirty control
    drive(1'b1, {2'b01, 6'd37, 24'h123456}, "R6");
    idle(1, "R8");
    // R4 void with arbitrary tag and body
    drive(1'b1, {2'b00, 6'd45, 24'hDEADBE}, "R4");
    drive(1'b1, {2'b00, 6'd0,  24'h000000}, "R4");
    idle(1, "R8");
    // R5 reserved, single pulse then quiet
    drive(1'b1, {2'b11, 6'd9, 24'h777777}, "R5");
    idle(2, "R5");
    // R9 back-to-back mixed kinds
    drive(1'b1, {2'b10, 6'd1, 24'h111111}, "R9");
    drive(1'b1, {2'b01, 6'd0, 24'h222222}, "R9");
    drive(1'b1, {2'b10, 6'd2, 24'h333333}, "R9");
    drive(1'b1, {2'b00, 6'd3, 24'h444444}, "R9");
    drive(1'b1, {2'b10, 6'd4, 24'h555555}, "R9");
    idle(2, "R8");
    // random mix with idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [31:0] p;
      p = $urandom;
      if ($urandom_range(0, 3) == 0) drive(1'b0, p, "R8");
      else drive(1'b1, p, "R9");
    end
    idle(3, "R8");
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule